// File: doc/BRIEF.md
# Data-side page translation cache

This block remembers recent data-side virtual-to-physical page translations so that most loads and stores avoid a page table walk. It keeps two small direct-mapped arrays, one for reads and one for writes. Each entry is tagged with the virtual page, the privilege mode and the address-space number that were current when it was filled. A plain lookup whose tags all match returns the physical address in the same cycle. Any other lookup goes to an external translator through a request/response port, and the block completes it when the translator answers.

Lookups that carry a non-zero access-type code are privileged. Examples are unchecked accesses, accesses to page table entries and accesses in an alternate mode. These lookups always go to the translator and never touch the arrays. Only one lookup is handled at a time. A flush input empties both arrays at once.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset every entry of both arrays is invalid. `done`, `hit`, `fault` and `walkReq` are low, and the first lookup of any address misses.
- R2: A plain lookup that hits raises `hit` and `done` in the same cycle as `lookupValid`. In that cycle `physAddr` is the cached physical page base (bits 31..13) joined with `vaddr` bits 12..0, and `walkReq` stays low.
- R3: A hit needs four things: a valid entry, an equal virtual page number (`vaddr` bits 31..13), a stored mode equal to `curMode` and a stored address-space number equal to `curAsn`. A change of mode or address-space number alone turns a hit into a miss.
- R4: `isWrite` = 0 selects the read array and `isWrite` = 1 selects the write array. A fill goes only to the array of the lookup that caused it.
- R5: The entry index is `vaddr` bits 16..13, giving 16 entries per array. A fill for another page with the same index replaces the old entry, and the old page then misses.
- R6: On a miss, `walkReq` goes high in the cycle after the lookup and stays high until the cycle in which `walkAck` is high. While `walkReq` is high, `walkVaddr`, `walkWrite` and `walkFlags` carry the captured lookup. In the `walkAck` cycle, `done` is high, `hit` is low and `physAddr` is `walkPaddr` bits 31..13 joined with the captured `vaddr` bits 12..0. A successful walk for a plain lookup fills the entry.
- R7: If `walkFault` is high with `walkAck`, then `done` and `fault` are high in that cycle and no entry is filled.
- R8: A lookup with `accFlags` not equal to 0 is always sent to the translator, even when a matching entry exists, and its result is never stored.
- R9: `flush` invalidates every entry of both arrays from the next cycle on. A flush in a `walkAck` cycle suppresses that fill.
- R10: `lookupValid` is ignored while a walk is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lookupValid | input | 1 | Lookup request |
| vaddr | input | 32 | Virtual address |
| isWrite | input | 1 | 1 = store, 0 = load |
| accFlags | input | 3 | Access type; 0 = plain, other = privileged bypass |
| curMode | input | 2 | Current privilege mode |
| curAsn | input | 8 | Current address-space number |
| hit | output | 1 | Lookup served from the cache |
| done | output | 1 | Lookup completes this cycle |
| fault | output | 1 | Translator reported a fault |
| physAddr | output | 32 | Translated address, valid with done |
| walkReq | output | 1 | Translation request to the walker |
| walkVaddr | output | 32 | Address being translated |
| walkWrite | output | 1 | Direction of the access being translated |
| walkFlags | output | 3 | Access type of the access being translated |
| walkAck | input | 1 | Walker response |
| walkFault | input | 1 | Walker reports a fault |
| walkPaddr | input | 32 | Walker result address |

## Verification
The bench uses the default parameters: 32-bit virtual and physical addresses, an 8 KB page and 4 index bits. With 16 entries per array, two pages that differ only in bit 17 fall on the same entry, so index conflicts (R5) are easy to provoke. The 2-bit mode and 8-bit address-space fields are wide enough to change one tag while the page tag stays the same. A behavioural model holds both arrays as integer tables and predicts every output on every clock. The walker answers after a chosen number of wait cycles, which places flushes and extra lookups inside a pending walk.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef struct packed {
    logic capture;
    logic fill;
    logic flushAll;
    logic useWalk;
  } ptcStrobes_t;

  typedef enum logic {ST_IDLE, ST_WALK} ptcState_t;
endpackage

// File: rtl/ptc_entry_array.sv
module ptc_entry_array #(
  parameter int VPN_W  = 19,
  parameter int PPN_W  = 19,
  parameter int IDX_W  = 4,
  parameter int MODE_W = 2,
  parameter int ASN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushAll,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [MODE_W-1:0] fillMode,
  input  logic [ASN_W-1:0]  fillAsn,
  input  logic [IDX_W-1:0]  lookIdx,
  input  logic [VPN_W-1:0]  lookVpn,
  input  logic [MODE_W-1:0] lookMode,
  input  logic [ASN_W-1:0]  lookAsn,
  output logic              lookHit,
  output logic [PPN_W-1:0]  lookPpn
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  validQ;
  logic [VPN_W-1:0]  vpnQ  [DEPTH];
  logic [PPN_W-1:0]  ppnQ  [DEPTH];
  logic [MODE_W-1:0] modeQ [DEPTH];
  logic [ASN_W-1:0]  asnQ  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || flushAll) validQ <= '0;
    else if (fillEn)        validQ[fillIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      vpnQ[fillIdx]  <= fillVpn;
      ppnQ[fillIdx]  <= fillPpn;
      modeQ[fillIdx] <= fillMode;
      asnQ[fillIdx]  <= fillAsn;
    end
  end

  always_comb begin
    lookHit = validQ[lookIdx] && (vpnQ[lookIdx] == lookVpn) &&
              (modeQ[lookIdx] == lookMode) && (asnQ[lookIdx] == lookAsn);
    lookPpn = ppnQ[lookIdx];
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll |=> !lookHit); // R9

  AST_FILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (fillEn && !flushAll) |=> (!(lookIdx == $past(fillIdx) && lookVpn == $past(fillVpn) &&
      lookMode == $past(fillMode) && lookAsn == $past(fillAsn)) || lookHit)); // R3
endmodule

// File: rtl/ptc_dpath.sv
module ptc_dpath
  import ptc_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 4,
  parameter int MODE_W    = 2,
  parameter int ASN_W     = 8,
  parameter int FLAG_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptcStrobes_t       strobes,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              isWrite,
  input  logic [FLAG_W-1:0] accFlags,
  input  logic [MODE_W-1:0] curMode,
  input  logic [ASN_W-1:0]  curAsn,
  input  logic [PA_W-1:0]   walkPaddr,
  output logic              hitRaw,
  output logic              capBypass,
  output logic [PA_W-1:0]   physAddr,
  output logic [VA_W-1:0]   walkVaddr,
  output logic              walkWrite,
  output logic [FLAG_W-1:0] walkFlags
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [VA_W-1:0]   capVaddr;
  logic              capWrite;
  logic [FLAG_W-1:0] capFlags;
  logic [MODE_W-1:0] capMode;
  logic [ASN_W-1:0]  capAsn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capVaddr <= '0;
      capWrite <= 1'b0;
      capFlags <= '0;
      capMode  <= '0;
      capAsn   <= '0;
    end else if (strobes.capture) begin
      capVaddr <= vaddr;
      capWrite <= isWrite;
      capFlags <= accFlags;
      capMode  <= curMode;
      capAsn   <= curAsn;
    end
  end

  logic [1:0]       hitVec;
  logic [PPN_W-1:0] ppnVec [2];

  for (genvar g = 0; g < 2; g++) begin : g_dir
    ptc_entry_array #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .MODE_W(MODE_W), .ASN_W(ASN_W)
    ) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .flushAll (strobes.flushAll),
      .fillEn   (strobes.fill && (capWrite == (g != 0))),
      .fillIdx  (capVaddr[PAGE_BITS +: IDX_W]),
      .fillVpn  (capVaddr[VA_W-1:PAGE_BITS]),
      .fillPpn  (walkPaddr[PA_W-1:PAGE_BITS]),
      .fillMode (capMode),
      .fillAsn  (capAsn),
      .lookIdx  (vaddr[PAGE_BITS +: IDX_W]),
      .lookVpn  (vaddr[VA_W-1:PAGE_BITS]),
      .lookMode (curMode),
      .lookAsn  (curAsn),
      .lookHit  (hitVec[g]),
      .lookPpn  (ppnVec[g])
    );
  end

  always_comb begin
    hitRaw    = hitVec[isWrite];
    capBypass = |capFlags;
    walkVaddr = capVaddr;
    walkWrite = capWrite;
    walkFlags = capFlags;
    if (strobes.useWalk)
      physAddr = {walkPaddr[PA_W-1:PAGE_BITS], capVaddr[PAGE_BITS-1:0]};
    else
      physAddr = {ppnVec[isWrite], vaddr[PAGE_BITS-1:0]};
  end

  AST_CAPTURE_TO_WALKER: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |=> (walkVaddr == $past(vaddr) && walkWrite == $past(isWrite))); // R6
endmodule

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        lookupValid,
  input  logic        privReq,
  input  logic        hitRaw,
  input  logic        capBypass,
  input  logic        walkAck,
  input  logic        walkFault,
  output ptcStrobes_t strobes,
  output logic        hit,
  output logic        done,
  output logic        fault,
  output logic        walkReq
);
  ptcState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD           = stateQ;
    strobes          = '0;
    strobes.flushAll = flush;
    hit              = 1'b0;
    done             = 1'b0;
    fault            = 1'b0;
    walkReq          = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (lookupValid) begin
          if (!privReq && hitRaw) begin
            hit  = 1'b1;
            done = 1'b1;
          end else begin
            strobes.capture = 1'b1;
            stateD          = ST_WALK;
          end
        end
      end
      default: begin
        walkReq         = 1'b1;
        strobes.useWalk = 1'b1;
        if (walkAck) begin
          done         = 1'b1;
          fault        = walkFault;
          strobes.fill = !walkFault && !capBypass && !flush;
          stateD       = ST_IDLE;
        end
      end
    endcase
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (walkReq && !walkAck) |=> walkReq); // R6

  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (done && !walkReq && !fault)); // R2

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (walkReq && lookupValid && !walkAck) |=> (walkReq && !hit)); // R10

  AST_REQ_FROM_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walkReq) |-> $past(lookupValid)); // R6
endmodule

// File: rtl/page_xlate_cache.sv
module page_xlate_cache
  import ptc_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 4,
  parameter int MODE_W    = 2,
  parameter int ASN_W     = 8,
  parameter int FLAG_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              isWrite,
  input  logic [FLAG_W-1:0] accFlags,
  input  logic [MODE_W-1:0] curMode,
  input  logic [ASN_W-1:0]  curAsn,
  output logic              hit,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   physAddr,
  output logic              walkReq,
  output logic [VA_W-1:0]   walkVaddr,
  output logic              walkWrite,
  output logic [FLAG_W-1:0] walkFlags,
  input  logic              walkAck,
  input  logic              walkFault,
  input  logic [PA_W-1:0]   walkPaddr
);
  ptcStrobes_t strobes;
  logic        hitRaw;
  logic        capBypass;

  ptc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .lookupValid (lookupValid),
    .privReq     (|accFlags),
    .hitRaw      (hitRaw),
    .capBypass   (capBypass),
    .walkAck     (walkAck),
    .walkFault   (walkFault),
    .strobes     (strobes),
    .hit         (hit),
    .done        (done),
    .fault       (fault),
    .walkReq     (walkReq)
  );

  ptc_dpath #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W),
    .MODE_W(MODE_W), .ASN_W(ASN_W), .FLAG_W(FLAG_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .vaddr     (vaddr),
    .isWrite   (isWrite),
    .accFlags  (accFlags),
    .curMode   (curMode),
    .curAsn    (curAsn),
    .walkPaddr (walkPaddr),
    .hitRaw    (hitRaw),
    .capBypass (capBypass),
    .physAddr  (physAddr),
    .walkVaddr (walkVaddr),
    .walkWrite (walkWrite),
    .walkFlags (walkFlags)
  );

  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && !hit && walkAck)); // R7
endmodule

// File: tb/page_xlate_cache_bench.sv
module page_xlate_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        isWrite = 1'b0;
  logic [2:0]  accFlags = '0;
  logic [1:0]  curMode = '0;
  logic [7:0]  curAsn = '0;
  logic        hit, done, fault, walkReq, walkWrite;
  logic [31:0] physAddr, walkVaddr;
  logic [2:0]  walkFlags;
  logic        walkAck = 1'b0;
  logic        walkFault = 1'b0;
  logic [31:0] walkPaddr = '0;

  always #5 clk = ~clk;

  page_xlate_cache u_page_xlate_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lookupValid(lookupValid),
    .vaddr(vaddr), .isWrite(isWrite), .accFlags(accFlags), .curMode(curMode),
    .curAsn(curAsn), .hit(hit), .done(done), .fault(fault), .physAddr(physAddr),
    .walkReq(walkReq), .walkVaddr(walkVaddr), .walkWrite(walkWrite),
    .walkFlags(walkFlags), .walkAck(walkAck), .walkFault(walkFault),
    .walkPaddr(walkPaddr)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string curReq  = "R1";

  // behavioural model: per direction, per index
  bit          mValid [2][16];
  longint      mVpn   [2][16];
  longint      mPpn   [2][16];
  int          mMode  [2][16];
  int          mAsn   [2][16];
  bit          mBusy = 0;
  logic [31:0] cVa;
  bit          cWr;
  int          cFlags, cMode, cAsn;

  task automatic chk(string tag, longint got, longint exp, string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic bit modelHit(logic [31:0] va, bit wr, int md, int asn);
    int ix = int'((va >> 13) & 15);
    return mValid[wr][ix] && mVpn[wr][ix] == longint'(va >> 13) &&
           mMode[wr][ix] == md && mAsn[wr][ix] == asn;
  endfunction

  task automatic tick();
    bit          eHit, eDone, eFault, eReq;
    logic [31:0] ePa;
    int          ix;
    #1;
    eHit = 0; eDone = 0; eFault = 0; eReq = 0; ePa = '0;
    if (!mBusy) begin
      if (lookupValid && accFlags == 0 && modelHit(vaddr, isWrite, int'(curMode), int'(curAsn))) begin
        eHit = 1; eDone = 1;
        ix = int'((vaddr >> 13) & 15);
        ePa = {mPpn[isWrite][ix][18:0], vaddr[12:0]};
      end
    end else begin
      eReq = 1;
      if (walkAck) begin
        eDone = 1; eFault = walkFault;
        ePa = {walkPaddr[31:13], cVa[12:0]};
      end
    end
    chk(curReq, hit, eHit, "hit");
    chk(curReq, done, eDone, "done");
    chk(curReq, fault, eFault, "fault");
    chk(curReq, walkReq, eReq, "walkReq");
    if (eDone) chk(curReq, physAddr, ePa, "physAddr");
    if (eReq) begin
      chk("R6", walkVaddr, cVa, "walkVaddr");
      chk("R6", walkWrite, cWr, "walkWrite");
      chk("R6", walkFlags, cFlags, "walkFlags");
    end
    // state update
    if (mBusy && walkAck && !walkFault && cFlags == 0 && !flush) begin
      ix = int'((cVa >> 13) & 15);
      mValid[cWr][ix] = 1; mVpn[cWr][ix] = longint'(cVa >> 13);
      mPpn[cWr][ix] = longint'(walkPaddr >> 13);
      mMode[cWr][ix] = cMode; mAsn[cWr][ix] = cAsn;
    end
    if (flush) for (int d = 0; d < 2; d++) for (int i = 0; i < 16; i++) mValid[d][i] = 0;
    if (mBusy) begin
      if (walkAck) mBusy = 0;
    end else if (lookupValid && !eHit) begin
      mBusy = 1; cVa = vaddr; cWr = isWrite; cFlags = int'(accFlags);
      cMode = int'(curMode); cAsn = int'(curAsn);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // one complete access; if the model predicts a walk, the walker answers after `waits` cycles
  task automatic access(string tag, logic [31:0] va, bit wr, int flags, int md, int asn,
                        logic [31:0] pa, bit flt, int waits, bit expHit,
                        bit strayLookup = 0, bit flushAtAck = 0);
    bit willHit;
    curReq = tag;
    willHit = (flags == 0) && modelHit(va, wr, md, asn);
    chk(tag, willHit, expHit, "expected hit/miss");
    vaddr = va; isWrite = wr; accFlags = 3'(flags); curMode = 2'(md); curAsn = 8'(asn);
    lookupValid = 1;
    tick();
    lookupValid = 0;
    if (!willHit) begin
      for (int w = 0; w < waits; w++) begin
        if (strayLookup) begin
          curReq = "R10";
          lookupValid = 1; vaddr = va ^ 32'h0004_0000; isWrite = ~wr; accFlags = 0;
        end
        tick();
        lookupValid = 0;
      end
      walkAck = 1; walkFault = flt; walkPaddr = pa; flush = flushAtAck;
      tick();
      walkAck = 0; walkFault = 0; flush = 0;
    end
  endtask

  localparam logic [31:0] VA_A = 32'h1234_4567;
  localparam logic [31:0] VA_B = VA_A ^ 32'h0002_0000; // same index, other page
  localparam logic [31:0] VA_C = 32'h0000_6abc;

  initial begin
    for (int d = 0; d < 2; d++) for (int i = 0; i < 16; i++) mValid[d][i] = 0;
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk("R1", done, 0, "done in reset");
    chk("R1", walkReq, 0, "walkReq in reset");
    chk("R1", hit, 0, "hit in reset");
    rst_n = 1;
    @(negedge clk);
    tick();
    access("R1", VA_A, 0, 0, 1, 5, 32'hABCD_E000, 0, 2, 0);
    access("R2", VA_A, 0, 0, 1, 5, 32'h0, 0, 0, 1);
    access("R2", VA_A + 32'h0000_1000, 0, 0, 1, 5, 32'h0, 0, 0, 1);
    access("R3", VA_A, 0, 0, 2, 5, 32'h0101_2000, 0, 1, 0);   // mode change
    access("R3", VA_A, 0, 0, 2, 6, 32'h0202_4000, 0, 0, 0);   // asn change
    access("R3", VA_A, 0, 0, 2, 6, 32'h0, 0, 0, 1);
    access("R4", VA_A, 1, 0, 2, 6, 32'h5555_6000, 0, 3, 0);   // write array empty
    access("R4", VA_A, 1, 0, 2, 6, 32'h0, 0, 0, 1);
    access("R4", VA_A, 0, 0, 2, 6, 32'h0, 0, 0, 1);
    access("R5", VA_B, 0, 0, 2, 6, 32'h7777_8000, 0, 1, 0);
    access("R5", VA_A, 0, 0, 2, 6, 32'h0202_4000, 0, 1, 0);   // evicted by VA_B
    access("R7", VA_C, 0, 0, 0, 1, 32'h9999_A000, 1, 2, 0);
    access("R7", VA_C, 0, 0, 0, 1, 32'h3333_C000, 0, 1, 0);   // fault did not fill
    access("R8", VA_A, 0, 4, 2, 6, 32'hEEEE_E000, 0, 1, 0);
    access("R8", VA_A, 0, 0, 2, 6, 32'h0, 0, 0, 1);           // old translation kept
    access("R10", VA_C, 1, 0, 0, 1, 32'h4444_0000, 0, 3, 0, 1);
    access("R10", VA_C, 1, 0, 0, 1, 32'h0, 0, 0, 1);
    curReq = "R9";
    flush = 1; tick(); flush = 0;
    access("R9", VA_A, 0, 0, 2, 6, 32'h6666_0000, 0, 1, 0);
    access("R9", VA_C, 1, 0, 0, 1, 32'h1111_0000, 0, 1, 0, 0, 1); // flush at ack
    access("R9", VA_C, 1, 0, 0, 1, 32'h1212_0000, 0, 1, 0);
    access("R9", VA_C, 1, 0, 0, 1, 32'h0, 0, 0, 1);
    repeat (2) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule